// File: doc/BRIEF.md
# Strobe-Driven FIFO Buffer with Read Rewind

This block is a first-in first-out store of 1024 words of 9 bits by default. It has no address inputs. Writes and reads are started by falling edges on two active-low strobes. The strobes may come from an unrelated timing source, so each one passes through a synchronizer into the system clock domain before its edges are detected. A write pointer and a read pointer, both internal, step through a register array.

Three active-low status flags report the fill state: empty, full and more-than-half-full. The half flag works on events and is not a plain level compare. A write sets it when that write takes the occupancy past half the depth. The release edge of a read strobe clears it once the occupancy is back at or below half. A separate active-low rewind input moves only the read pointer back to location zero, so data already written can be played out again.

The output word is held in a register. A valid flag stands in for a driven bus: it is high from an accepted read until that read strobe is released.

Top module: `strobe_fifo`

## Requirements
- R1: Words leave in the order they were written. With `ADDR_W`=10 the depth is 1024 words of 9 bits, and `ADDR_W`=9 gives 512 words.
- R2: A write happens on a falling edge of `wr_n`. While the buffer holds the full depth, write edges are ignored, and the refused word never appears on `rd_data`.
- R3: A read happens on a falling edge of `rd_n`. While the buffer is empty, read edges are ignored: `rd_valid` stays 0 and the read pointer does not move.
- R4: While `rst_n` is low, both pointers return to location 0. After reset, `empty_n`=0, `full_n`=1, `half_n`=1 and `rd_valid`=0.
- R5: `empty_n` is 0 exactly when the occupancy is zero. It returns to 1 after an accepted write.
- R6: `full_n` goes to 0 after the full depth of writes with no reads. It returns to 1 after one accepted read.
- R7: `half_n` goes to 0 on the accepted write that takes the occupancy above half the depth. It returns to 1 on the release (rising) edge of `rd_n` when the occupancy is at or below half the depth.
- R8: A falling edge of `rt_n` sets the read pointer to 0 and leaves the write pointer unchanged. The occupancy becomes the number of words written since reset, and `half_n` is re-evaluated from that value.
- R9: While the synchronized `rt_n` is low, edges on `wr_n` and `rd_n` are ignored.
- R10: A write and a read detected in the same clock both take effect. Both pointers advance and the occupancy is unchanged.
- R11: `rd_valid` goes to 1 only after an accepted read, and it returns to 0 on the release of `rd_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Active-low write strobe; its falling edge writes a word |
| rd_n | input | 1 | Active-low read strobe; its falling edge reads a word |
| rt_n | input | 1 | Active-low rewind; its falling edge moves the read pointer to 0 |
| wr_data | input | DATA_W | Word to write; must be held stable while `wr_n` is low |
| rd_data | output | DATA_W | Last word read |
| rd_valid | output | 1 | High from an accepted read until `rd_n` is released |
| empty_n | output | 1 | Low when the buffer is empty |
| full_n | output | 1 | Low when the buffer holds the full depth |
| half_n | output | 1 | Low when the buffer is more than half full (event-driven) |

## Verification
A write edge and a read edge can be detected in the same clock. The bench provokes this by pulling `wr_n` and `rd_n` low on the same clock phase while three words are stored. It then judges the result at the ports. The read must return the oldest word. The three words that follow must come out in order, ending with the word written during the overlap, and the buffer must then report empty.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
    // Index of each strobe in the synchronized strobe vectors.
    localparam int STB_WR  = 0;
    localparam int STB_RD  = 1;
    localparam int STB_RT  = 2;
    localparam int NUM_STB = 3;
endpackage

// File: rtl/sfifo_strobe_sync.sv
module sfifo_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic lvl_q,
    output logic prev_q
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    logic              prev_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_n};
        prev_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign lvl_q = chain_q[STAGES-1];
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_STB-1:0] stb_lvl,
    input  logic [NUM_STB-1:0] stb_prev,
    input  logic [DATA_W-1:0]  rdata,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  waddr,
    output logic [ADDR_W-1:0]  raddr,
    output logic [DATA_W-1:0]  dout,
    output logic               dout_vld,
    output logic               empty_n,
    output logic               full_n,
    output logic               half_n,
    output logic [ADDR_W:0]    cnt,
    output logic               wr_fall,
    output logic               rd_fall,
    output logic               rt_fall
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_V  = PW'(DEPTH / 2);

    typedef struct packed {
        logic [PW-1:0]     wptr;
        logic [PW-1:0]     rptr;
        logic [PW-1:0]     cnt;
        logic              half_n;
        logic              vld;
        logic [DATA_W-1:0] dout;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic busy, wr_ok, rd_ok, rd_rise;
    logic wr_fall_w, rd_fall_w, rt_fall_w;

    always_comb begin
        st_d      = st_q;
        wr_fall_w = stb_prev[STB_WR] & ~stb_lvl[STB_WR];
        rd_fall_w = stb_prev[STB_RD] & ~stb_lvl[STB_RD];
        rt_fall_w = stb_prev[STB_RT] & ~stb_lvl[STB_RT];
        busy      = ~stb_lvl[STB_RT];
        rd_rise   = ~stb_prev[STB_RD] & stb_lvl[STB_RD] & ~busy;
        wr_ok     = wr_fall_w & ~busy & (st_q.cnt != DEPTH_V);
        rd_ok     = rd_fall_w & ~busy & (st_q.cnt != '0);

        if (wr_ok) begin
            st_d.wptr = st_q.wptr + 1'b1;
        end
        if (rd_ok) begin
            st_d.rptr = st_q.rptr + 1'b1;
            st_d.dout = rdata;
            st_d.vld  = 1'b1;
        end
        if (rd_rise) begin
            st_d.vld = 1'b0;
        end

        case ({wr_ok, rd_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase

        if (wr_ok && (st_d.cnt > HALF_V)) begin
            st_d.half_n = 1'b0;
        end
        if (rd_rise && (st_q.cnt <= HALF_V)) begin
            st_d.half_n = 1'b1;
        end

        if (rt_fall_w) begin
            st_d.rptr   = '0;
            st_d.cnt    = (st_q.wptr > DEPTH_V) ? DEPTH_V : st_q.wptr;
            st_d.half_n = ~(st_d.cnt > HALF_V);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wptr: '0, rptr: '0, cnt: '0, half_n: 1'b1,
                      vld: 1'b0, dout: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en    = wr_ok;
    assign waddr    = st_q.wptr[ADDR_W-1:0];
    assign raddr    = st_q.rptr[ADDR_W-1:0];
    assign dout     = st_q.dout;
    assign dout_vld = st_q.vld;
    assign empty_n  = (st_q.cnt != '0);
    assign full_n   = (st_q.cnt != DEPTH_V);
    assign half_n   = st_q.half_n;
    assign cnt      = st_q.cnt;
    assign wr_fall  = wr_fall_w;
    assign rd_fall  = rd_fall_w;
    assign rt_fall  = rt_fall_w;
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 9,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              rt_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n
);
    logic [NUM_STB-1:0] raw_n, stb_lvl, stb_prev;
    logic               wr_en;
    logic [ADDR_W-1:0]  waddr, raddr;
    logic [DATA_W-1:0]  rdata;
    logic [ADDR_W:0]    cnt_q;
    logic               wr_fall, rd_fall, rt_fall;

    always_comb begin
        raw_n         = '1;
        raw_n[STB_WR] = wr_n;
        raw_n[STB_RD] = rd_n;
        raw_n[STB_RT] = rt_n;
    end

    for (genvar g = 0; g < NUM_STB; g++) begin : g_sync
        sfifo_strobe_sync #(.STAGES(SYNC_STGS)) sync_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_n(raw_n[g]),
            .lvl_q  (stb_lvl[g]),
            .prev_q (stb_prev[g])
        );
    end

    sfifo_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
        .clk  (clk),
        .wr_en(wr_en),
        .waddr(waddr),
        .wdata(wr_data),
        .raddr(raddr),
        .rdata(rdata)
    );

    sfifo_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_lvl (stb_lvl),
        .stb_prev(stb_prev),
        .rdata   (rdata),
        .wr_en   (wr_en),
        .waddr   (waddr),
        .raddr   (raddr),
        .dout    (rd_data),
        .dout_vld(rd_valid),
        .empty_n (empty_n),
        .full_n  (full_n),
        .half_n  (half_n),
        .cnt     (cnt_q),
        .wr_fall (wr_fall),
        .rd_fall (rd_fall),
        .rt_fall (rt_fall)
    );
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
    parameter int ADDR_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_fall,
    input logic            rd_fall,
    input logic            rt_fall,
    input logic [ADDR_W:0] cnt_q,
    input logic            empty_n,
    input logic            full_n,
    input logic            half_n,
    input logic            rd_valid
);
    localparam logic [ADDR_W:0] HALF_V = (ADDR_W + 1)'((1 << ADDR_W) / 2);

    // R2, R6: a full buffer stays full unless a read or rewind occurs
    a_r2_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !rd_fall && !rt_fall) |=> !full_n);

    // R5: an empty buffer stays empty unless a write or rewind occurs
    a_r5_empty_until_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !wr_fall && !rt_fall) |=> !empty_n);

    // R3: a read edge on an empty buffer yields no valid data
    a_r3_no_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_fall) |=> !rd_valid);

    // R7: the half flag asserts only with occupancy above half
    a_r7_half_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(half_n) |-> (cnt_q > HALF_V));

    // R10: outside a rewind the occupancy moves by at most one word per clock
    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_fall |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1
                      || cnt_q == $past(cnt_q) - 1'b1));

    // R11: valid data appears only after a read edge
    a_r11_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(rd_fall));
endmodule

bind strobe_fifo strobe_fifo_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fall (wr_fall),
    .rd_fall (rd_fall),
    .rt_fall (rt_fall),
    .cnt_q   (cnt_q),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n),
    .rd_valid(rd_valid)
);

// File: tb/strobe_fifo_tb_top.sv
module strobe_fifo_tb_top;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 9;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HALF   = DEPTH / 2;
    localparam int NVEC   = 8;

    // Each vector: {is_read, value}. A write stores value; a read expects it.
    localparam logic [DATA_W:0] VEC [NVEC] = '{
        {1'b0, 9'h101}, {1'b0, 9'h0A5}, {1'b0, 9'h1FF}, {1'b1, 9'h101},
        {1'b0, 9'h000}, {1'b1, 9'h0A5}, {1'b1, 9'h1FF}, {1'b1, 9'h000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic rd_valid, empty_n, full_n, half_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    strobe_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    function automatic logic [DATA_W-1:0] pat(int i);
        return DATA_W'((i * 37 + 5) % 512);
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_write(logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_data = d;
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(output logic [DATA_W-1:0] d, output logic v);
        @(negedge clk);
        rd_n = 1'b0;
        repeat (4) @(negedge clk);
        d = rd_data;
        v = rd_valid;
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_rewind(bit strobe_inside);
        @(negedge clk);
        rt_n = 1'b0;
        repeat (4) @(negedge clk);
        if (strobe_inside) begin
            wr_data = 9'h1AA;
            wr_n = 1'b0;
            rd_n = 1'b0;
            repeat (4) @(negedge clk);
            wr_n = 1'b1;
            rd_n = 1'b1;
            repeat (4) @(negedge clk);
        end
        rt_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        logic v;
        bit order_ok;

        // R4: reset state
        do_reset();
        chk("R4 empty_n", 16'(empty_n), 16'd0);
        chk("R4 full_n", 16'(full_n), 16'd1);
        chk("R4 half_n", 16'(half_n), 16'd1);
        chk("R4 rd_valid", 16'(rd_valid), 16'd0);

        // R1: vector table of mixed writes and reads
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][DATA_W]) begin
                do_read(d, v);
                chk("R1 table read", 16'(d), 16'(VEC[i][DATA_W-1:0]));
                chk("R11 valid during read", 16'(v), 16'd1);
            end else begin
                do_write(VEC[i][DATA_W-1:0]);
                chk("R5 not empty after write", 16'(empty_n), 16'd1);
            end
        end
        chk("R5 empty after drain", 16'(empty_n), 16'd0);
        chk("R11 valid after release", 16'(rd_valid), 16'd0);

        // R3: read on empty is ignored
        do_read(d, v);
        chk("R3 no valid on empty", 16'(v), 16'd0);
        do_write(9'h0C3);
        do_read(d, v);
        chk("R3 pointer unmoved", 16'(d), 16'h0C3);
        chk("R5 empty again", 16'(empty_n), 16'd0);

        // R10: simultaneous write and read edges
        do_reset();
        for (int i = 0; i < 3; i++) do_write(pat(i));
        @(negedge clk);
        wr_data = 9'h111;
        wr_n = 1'b0;
        rd_n = 1'b0;
        repeat (4) @(negedge clk);
        d = rd_data;
        wr_n = 1'b1;
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 overlap read data", 16'(d), 16'(pat(0)));
        do_read(d, v);
        chk("R10 next word", 16'(d), 16'(pat(1)));
        do_read(d, v);
        chk("R10 next word 2", 16'(d), 16'(pat(2)));
        do_read(d, v);
        chk("R10 overlap write stored", 16'(d), 16'h111);
        chk("R10 count unchanged, now empty", 16'(empty_n), 16'd0);

        // R6, R7, R2: fill to the top
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            do_write(pat(i));
            if (i == HALF - 1) chk("R7 half not yet", 16'(half_n), 16'd1);
            if (i == HALF) chk("R7 half set", 16'(half_n), 16'd0);
        end
        chk("R6 full set", 16'(full_n), 16'd0);
        do_write(9'h155);
        chk("R2 still full", 16'(full_n), 16'd0);
        order_ok = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            do_read(d, v);
            if (d !== pat(i)) order_ok = 1'b0;
            if (i == 0) chk("R6 full cleared", 16'(full_n), 16'd1);
            if (i == HALF - 2) chk("R7 half held", 16'(half_n), 16'd0);
            if (i == HALF - 1) chk("R7 half cleared", 16'(half_n), 16'd1);
        end
        chk("R1 full-depth order", 16'(order_ok), 16'd1);
        chk("R2 refused word absent", 16'(empty_n), 16'd0);

        // R8, R9: rewind with strobes inside the rewind window
        do_reset();
        for (int i = 0; i < 5; i++) do_write(pat(i + 100));
        do_read(d, v);
        do_read(d, v);
        do_rewind(1'b1);
        for (int i = 0; i < 5; i++) begin
            do_read(d, v);
            chk("R8 replay order", 16'(d), 16'(pat(i + 100)));
        end
        do_read(d, v);
        chk("R9 strobes during rewind ignored", 16'(v), 16'd0);
        chk("R9 empty after replay", 16'(empty_n), 16'd0);

        // R8: half flag re-evaluated by rewind
        do_reset();
        for (int i = 0; i < 600; i++) do_write(pat(i));
        for (int i = 0; i < 100; i++) do_read(d, v);
        chk("R7 half cleared at 500", 16'(half_n), 16'd1);
        do_rewind(1'b0);
        chk("R8 half set by rewind", 16'(half_n), 16'd0);
        do_read(d, v);
        chk("R8 first word after rewind", 16'(d), 16'(pat(0)));

        // R4: reset with data held
        do_reset();
        chk("R4 empty after reset", 16'(empty_n), 16'd0);
        chk("R4 half clear after reset", 16'(half_n), 16'd1);
        do_write(9'h03C);
        do_read(d, v);
        chk("R4 pointers at zero", 16'(d), 16'h03C);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule